// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an external SDRAM device out of power-up. After a one-cycle start pulse it keeps the command bus at NOP for a programmable number of microsecond ticks. It then issues one PRECHARGE-ALL, a programmable number of AUTO-REFRESH commands and one LOAD-MODE that carries a 14-bit mode word on the address lines. After a final settle wait it raises `done`. Every delay and count is read from configuration inputs, so one netlist can serve devices with different timing.

The minimum gap that follows each command comes from its own configuration field. The gap after PRECHARGE-ALL uses the precharge time. The gap after each AUTO-REFRESH uses the refresh cycle time. The wait between LOAD-MODE and `done` uses the mode-register set time. A timing field of 0 or 1 gives a one-cycle gap. Normal read and write traffic, periodic refresh and pads are handled elsewhere.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `memCmd` is NOP, `memAddr` is zero, and `busy` and `done` are both low.
- R2: A start pulse sampled while idle or done raises `busy` in the next cycle. The sequencer then waits until `cfgPwrDelayUs` microsecond ticks have been seen in the wait cycles. PRECHARGE-ALL follows in the next cycle. A delay of 0 issues PRECHARGE-ALL in the second cycle after the start edge.
- R3: PRECHARGE-ALL drives only address bit 10 high. It is issued exactly once per sequence. The next command comes exactly max(`cfgTrp`,1) cycles later.
- R4: Exactly `cfgRefreshCnt` AUTO-REFRESH commands are issued, a count of 0 skipping them. Each one is followed by its next command exactly max(`cfgTrc`,1) cycles later.
- R5: LOAD-MODE is issued exactly once, after the refreshes, with `memAddr` equal to `cfgModeVal`. `done` rises exactly max(`cfgTmrd`,1) cycles after it.
- R6: In every cycle that carries no command, `memCmd` is NOP and `memAddr` is zero.
- R7: `busy` stays high from the cycle after an accepted start until `done` rises. `busy` and `done` are never high together. `done` stays high until the next accepted start.
- R8: A start pulse that arrives while `busy` is high has no effect on the command sequence or its timing.
- R9: A start pulse while `done` is high clears `done`, raises `busy` in the next cycle and runs a full new sequence.
- R10: The command encoding on `memCmd` is NOP = 0, PRECHARGE-ALL = 1, AUTO-REFRESH = 2 and LOAD-MODE = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle pulse each microsecond |
| startPulse | input | 1 | Request to run the power-up sequence |
| cfgPwrDelayUs | input | 16 | Power-up wait, in microsecond ticks |
| cfgRefreshCnt | input | 4 | Number of AUTO-REFRESH commands |
| cfgModeVal | input | 14 | Word driven on the address bus with LOAD-MODE |
| cfgTrp | input | 4 | Cycles from PRECHARGE-ALL to the next command |
| cfgTrc | input | 4 | Cycles from AUTO-REFRESH to the next command |
| cfgTmrd | input | 4 | Cycles from LOAD-MODE to `done` |
| memCmd | output | 2 | SDRAM command (encoding in R10) |
| memAddr | output | 14 | SDRAM address lines |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |

## Verification
The gap assertions read the configuration inputs live, so they assume those fields do not change while `busy` is high. The stimulus writes the configuration only while the block is idle or done. The assertions also assume `usTick` is a plain pulse with no relation to the command state. The bench therefore drives it from a free-running divider whose period differs between scenarios, and this includes a tick in every cycle. Start pulses during a run are placed in the power-up wait, where re-entry would most plainly show.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // SDRAM command codes as driven on the command bus
  typedef enum logic [1:0] {
    CMD_NOP    = 2'd0,
    CMD_PREALL = 2'd1,
    CMD_AREF   = 2'd2,
    CMD_LMODE  = 2'd3
  } memCmd_e;

  // Which timing field loads the shared gap counter
  typedef enum logic [1:0] {
    GAP_TRP  = 2'd0,
    GAP_TRC  = 2'd1,
    GAP_TMRD = 2'd2
  } gapSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    loadUs;
    logic    decUs;
    logic    loadRef;
    logic    decRef;
    logic    loadGap;
    logic    decGap;
    gapSel_e gapSel;
    logic    driveAllBank;
    logic    driveMode;
  } seqStrobe_t;

endpackage

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int PWR_W       = 16,
  parameter int REF_W       = 4,
  parameter int TIM_W       = 4,
  parameter int ADDR_W      = 14,
  parameter int ALLBANK_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [PWR_W-1:0]  cfgPwrDelayUs,
  input  logic [REF_W-1:0]  cfgRefreshCnt,
  input  logic [ADDR_W-1:0] cfgModeVal,
  input  logic [TIM_W-1:0]  cfgTrp,
  input  logic [TIM_W-1:0]  cfgTrc,
  input  logic [TIM_W-1:0]  cfgTmrd,
  output logic              usZero,
  output logic              usOne,
  output logic              refZero,
  output logic              refOne,
  output logic              gapOne,
  output logic              gapShort,
  output logic [ADDR_W-1:0] memAddr
);

  localparam logic [ADDR_W-1:0] ALL_BANK_WORD = {{(ADDR_W-1){1'b0}}, 1'b1} << ALLBANK_BIT;
  localparam logic [PWR_W-1:0]  PWR_ONE = {{(PWR_W-1){1'b0}}, 1'b1};
  localparam logic [REF_W-1:0]  REF_ONE = {{(REF_W-1){1'b0}}, 1'b1};
  localparam logic [TIM_W-1:0]  TIM_ONE = {{(TIM_W-1){1'b0}}, 1'b1};

  logic [PWR_W-1:0] usCnt;
  logic [REF_W-1:0] refCnt;
  logic [TIM_W-1:0] gapCnt;
  logic [TIM_W-1:0] selT;

  // Timing field chosen by the control for the gap being started
  always_comb begin
    case (strb.gapSel)
      GAP_TRP: selT = cfgTrp;
      GAP_TRC: selT = cfgTrc;
      default: selT = cfgTmrd;
    endcase
  end

  // A field of 0 or 1 needs no wait state at all
  assign gapShort = (selT <= TIM_ONE);

  // Microsecond countdown for the power-up wait
  always_ff @(posedge clk) begin
    if (!rstN)             usCnt <= '0;
    else if (strb.loadUs)  usCnt <= cfgPwrDelayUs;
    else if (strb.decUs)   usCnt <= usCnt - PWR_ONE;
  end

  // Remaining refresh commands
  always_ff @(posedge clk) begin
    if (!rstN)             refCnt <= '0;
    else if (strb.loadRef) refCnt <= cfgRefreshCnt;
    else if (strb.decRef)  refCnt <= refCnt - REF_ONE;
  end

  // Shared gap counter: loaded with T-1, leaves the wait when it reads 1
  always_ff @(posedge clk) begin
    if (!rstN)             gapCnt <= '0;
    else if (strb.loadGap) gapCnt <= selT - TIM_ONE;
    else if (strb.decGap)  gapCnt <= gapCnt - TIM_ONE;
  end

  assign usZero  = (usCnt == '0);
  assign usOne   = (usCnt == PWR_ONE);
  assign refZero = (refCnt == '0);
  assign refOne  = (refCnt == REF_ONE);
  assign gapOne  = (gapCnt == TIM_ONE);

  // Address bus: mode word, all-bank flag, or quiet
  always_comb begin
    if (strb.driveMode)         memAddr = cfgModeVal;
    else if (strb.driveAllBank) memAddr = ALL_BANK_WORD;
    else                        memAddr = '0;
  end

  // R2: the control never counts a tick past zero
  a_r2_us_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.decUs |-> !usZero)
    else $error("a_r2_us_no_underflow");

  // R4: refresh count never wraps
  a_r4_ref_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.decRef |-> !refZero)
    else $error("a_r4_ref_no_underflow");

  // R3: a wait state only decrements while more than one cycle remains
  a_r3_gap_dec_legal: assert property (@(posedge clk) disable iff (!rstN)
    strb.decGap |-> (gapCnt > TIM_ONE))
    else $error("a_r3_gap_dec_legal");

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       usTick,
  input  logic       usZero,
  input  logic       usOne,
  input  logic       refZero,
  input  logic       refOne,
  input  logic       gapOne,
  input  logic       gapShort,
  output seqStrobe_t strb,
  output memCmd_e    memCmd,
  output logic       busy,
  output logic       done
);

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_PRE, S_TRP, S_REF, S_TRC, S_LMR, S_TMRD, S_DONE
  } seqState_e;

  seqState_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt         = state;
    strb        = '0;
    strb.gapSel = GAP_TRP;
    case (state)
      S_IDLE, S_DONE: begin
        if (startPulse) begin
          nxt          = S_PWR;
          strb.loadUs  = 1'b1;
          strb.loadRef = 1'b1;
        end
      end
      S_PWR: begin
        if (usZero || (usTick && usOne)) nxt = S_PRE;
        else if (usTick)                 strb.decUs = 1'b1;
      end
      S_PRE: begin
        strb.gapSel       = GAP_TRP;
        strb.loadGap      = 1'b1;
        strb.driveAllBank = 1'b1;
        if (gapShort) nxt = refZero ? S_LMR : S_REF;
        else          nxt = S_TRP;
      end
      S_TRP: begin
        if (gapOne) nxt = refZero ? S_LMR : S_REF;
        else        strb.decGap = 1'b1;
      end
      S_REF: begin
        strb.gapSel  = GAP_TRC;
        strb.loadGap = 1'b1;
        strb.decRef  = 1'b1;
        if (gapShort) nxt = refOne ? S_LMR : S_REF;
        else          nxt = S_TRC;
      end
      S_TRC: begin
        if (gapOne) nxt = refZero ? S_LMR : S_REF;
        else        strb.decGap = 1'b1;
      end
      S_LMR: begin
        strb.gapSel    = GAP_TMRD;
        strb.loadGap   = 1'b1;
        strb.driveMode = 1'b1;
        nxt = gapShort ? S_DONE : S_TMRD;
      end
      S_TMRD: begin
        if (gapOne) nxt = S_DONE;
        else        strb.decGap = 1'b1;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    case (state)
      S_PRE:   memCmd = CMD_PREALL;
      S_REF:   memCmd = CMD_AREF;
      S_LMR:   memCmd = CMD_LMODE;
      default: memCmd = CMD_NOP;
    endcase
  end

  assign busy = (state != S_IDLE) && (state != S_DONE);
  assign done = (state == S_DONE);

  // R7: the two status flags are exclusive
  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done))
    else $error("a_r7_busy_done_excl");

  // R8: a start during a run never re-enters the power-up wait
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && state != S_PWR) |=> (state != S_PWR))
    else $error("a_r8_start_ignored");

  // R7: done holds until a new start
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startPulse) |=> done)
    else $error("a_r7_done_holds");

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int PWR_W       = 16,
  parameter int REF_W       = 4,
  parameter int TIM_W       = 4,
  parameter int ADDR_W      = 14,
  parameter int ALLBANK_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              startPulse,
  input  logic [PWR_W-1:0]  cfgPwrDelayUs,
  input  logic [REF_W-1:0]  cfgRefreshCnt,
  input  logic [ADDR_W-1:0] cfgModeVal,
  input  logic [TIM_W-1:0]  cfgTrp,
  input  logic [TIM_W-1:0]  cfgTrc,
  input  logic [TIM_W-1:0]  cfgTmrd,
  output logic [1:0]        memCmd,
  output logic [ADDR_W-1:0] memAddr,
  output logic              busy,
  output logic              done
);

  localparam int SINCE_W = TIM_W + 2;

  seqStrobe_t strb;
  memCmd_e    cmdInt;
  logic usZero, usOne, refZero, refOne, gapOne, gapShort;

  sdram_init_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .usTick     (usTick),
    .usZero     (usZero),
    .usOne      (usOne),
    .refZero    (refZero),
    .refOne     (refOne),
    .gapOne     (gapOne),
    .gapShort   (gapShort),
    .strb       (strb),
    .memCmd     (cmdInt),
    .busy       (busy),
    .done       (done)
  );

  sdram_init_dp #(
    .PWR_W       (PWR_W),
    .REF_W       (REF_W),
    .TIM_W       (TIM_W),
    .ADDR_W      (ADDR_W),
    .ALLBANK_BIT (ALLBANK_BIT)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .cfgPwrDelayUs (cfgPwrDelayUs),
    .cfgRefreshCnt (cfgRefreshCnt),
    .cfgModeVal    (cfgModeVal),
    .cfgTrp        (cfgTrp),
    .cfgTrc        (cfgTrc),
    .cfgTmrd       (cfgTmrd),
    .usZero        (usZero),
    .usOne         (usOne),
    .refZero       (refZero),
    .refOne        (refOne),
    .gapOne        (gapOne),
    .gapShort      (gapShort),
    .memAddr       (memAddr)
  );

  assign memCmd = cmdInt;

  // Gap observer for the command-spacing assertions
  logic [SINCE_W-1:0] sinceCmd;
  memCmd_e            prevCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceCmd <= '0;
      prevCmd  <= CMD_NOP;
    end else if (cmdInt != CMD_NOP) begin
      sinceCmd <= {{(SINCE_W-1){1'b0}}, 1'b1};
      prevCmd  <= cmdInt;
    end else if (sinceCmd != '1) begin
      sinceCmd <= sinceCmd + 1'b1;
    end
  end

  function automatic logic [SINCE_W-1:0] effGap(input logic [TIM_W-1:0] t);
    effGap = (t == '0) ? {{(SINCE_W-1){1'b0}}, 1'b1} : {2'b00, t};
  endfunction

  // R3: spacing after PRECHARGE-ALL
  a_r3_trp_gap: assert property (@(posedge clk) disable iff (!rstN)
    (cmdInt != CMD_NOP && prevCmd == CMD_PREALL) |-> (sinceCmd >= effGap(cfgTrp)))
    else $error("a_r3_trp_gap");

  // R4: spacing after AUTO-REFRESH
  a_r4_trc_gap: assert property (@(posedge clk) disable iff (!rstN)
    (cmdInt != CMD_NOP && prevCmd == CMD_AREF) |-> (sinceCmd >= effGap(cfgTrc)))
    else $error("a_r4_trc_gap");

  // R5: done only after LOAD-MODE and its settle time
  a_r5_tmrd_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (prevCmd == CMD_LMODE && sinceCmd >= effGap(cfgTmrd)))
    else $error("a_r5_tmrd_gap");

  // R5: mode word on the address lines
  a_r5_mode_addr: assert property (@(posedge clk) disable iff (!rstN)
    (cmdInt == CMD_LMODE) |-> (memAddr == cfgModeVal))
    else $error("a_r5_mode_addr");

  // R6: quiet address on NOP cycles
  a_r6_nop_addr: assert property (@(posedge clk) disable iff (!rstN)
    (cmdInt == CMD_NOP) |-> (memAddr == '0))
    else $error("a_r6_nop_addr");

endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        usTick = 1'b0;
  logic        startPulse = 1'b0;
  logic [15:0] cfgPwrDelayUs = 16'd0;
  logic [3:0]  cfgRefreshCnt = 4'd0;
  logic [13:0] cfgModeVal = 14'd0;
  logic [3:0]  cfgTrp = 4'd0, cfgTrc = 4'd0, cfgTmrd = 4'd0;
  logic [1:0]  memCmd;
  logic [13:0] memAddr;
  logic        busy, done;

  always #5 clk = ~clk;

  sdram_init_seq dut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .startPulse(startPulse),
    .cfgPwrDelayUs(cfgPwrDelayUs), .cfgRefreshCnt(cfgRefreshCnt),
    .cfgModeVal(cfgModeVal), .cfgTrp(cfgTrp), .cfgTrc(cfgTrc), .cfgTmrd(cfgTmrd),
    .memCmd(memCmd), .memAddr(memAddr), .busy(busy), .done(done)
  );

  int vectors = 0;
  int errs = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Microsecond tick divider
  int  tickPer = 1;
  int  tickCtr = 0;
  bit  tickEn = 0;
  always @(negedge clk) begin
    #1;
    if (tickEn) begin
      tickCtr++;
      usTick = ((tickCtr % tickPer) == 0);
    end else begin
      usTick = 1'b0;
    end
  end

  // Behavioural reference: phase 0 idle, 1 power-up, 2 gap, 3 done
  int mPhase = 0, mUs = 0, mRef = 0, mWait = 0, mLast = 0;
  int eCmd = 0, eAddr = 0;
  bit eBusy = 0, eDone = 0;

  function automatic int atLeastOne(input int t);
    return (t < 1) ? 1 : t;
  endfunction

  task automatic issue(input int c);
    int t;
    eCmd  = c;
    mLast = c;
    mPhase = 2;
    t = (c == 1) ? int'(cfgTrp) : (c == 2) ? int'(cfgTrc) : int'(cfgTmrd);
    mWait = atLeastOne(t) - 1;
    eAddr = (c == 1) ? 'h400 : (c == 3) ? int'(cfgModeVal) : 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; eCmd = 0; eAddr = 0; eBusy = 0; eDone = 0; mLast = 0;
    end else begin
      eCmd = 0;
      eAddr = 0;
      case (mPhase)
        0, 3: if (startPulse) begin
          mPhase = 1; mUs = int'(cfgPwrDelayUs); mRef = int'(cfgRefreshCnt);
          eBusy = 1; eDone = 0;
        end
        1: begin
          if (mUs == 0 || (usTick && mUs == 1)) issue(1);
          else if (usTick) mUs--;
        end
        default: begin
          if (mWait > 0) mWait--;
          else if (mLast == 3) begin mPhase = 3; eBusy = 0; eDone = 1; end
          else if (mRef > 0) begin mRef--; issue(2); end
          else issue(3);
        end
      endcase
    end
  end

  // Per-cycle comparison plus a measured gap check
  int lastSeen = 0, sinceSeen = 0;
  int preSeen = 0, refSeen = 0, lmrSeen = 0, firstCmd = -1;
  bit compareOn = 0;

  always @(negedge clk) begin
    if (compareOn) begin
      string tg;
      tg = (!rstN) ? "R1" : (eCmd == 1) ? "R3" : (eCmd == 2) ? "R4" : (eCmd == 3) ? "R5" : "R6";
      check(int'(memCmd) == eCmd, {tg, " cmd"}, int'(memCmd), eCmd);
      check(int'(memAddr) == eAddr, {tg, " addr"}, int'(memAddr), eAddr);
      check(busy == eBusy, (!rstN) ? "R1 busy" : "R7 busy", int'(busy), int'(eBusy));
      check(done == eDone, (!rstN) ? "R1 done" : "R7 done", int'(done), int'(eDone));
    end
    sinceSeen++;
    if (rstN && memCmd != 2'd0) begin
      if (lastSeen == 1) check(sinceSeen >= atLeastOne(int'(cfgTrp)), "R3 gap", sinceSeen, atLeastOne(int'(cfgTrp)));
      if (lastSeen == 2) check(sinceSeen >= atLeastOne(int'(cfgTrc)), "R4 gap", sinceSeen, atLeastOne(int'(cfgTrc)));
      if (firstCmd < 0) firstCmd = int'(memCmd);
      if (memCmd == 2'd1) preSeen++;
      if (memCmd == 2'd2) refSeen++;
      if (memCmd == 2'd3) lmrSeen++;
      lastSeen = int'(memCmd);
      sinceSeen = 0;
    end
  end

  task automatic setCfg(input logic [15:0] d, input logic [3:0] n, input logic [13:0] m,
                        input logic [3:0] trp, input logic [3:0] trc, input logic [3:0] tmrd,
                        input int per);
    @(negedge clk); #2;
    cfgPwrDelayUs = d; cfgRefreshCnt = n; cfgModeVal = m;
    cfgTrp = trp; cfgTrc = trc; cfgTmrd = tmrd; tickPer = per;
  endtask

  // Runs one sequence; optional start pulse injected in the power-up wait (R8)
  task automatic runSeq(input bit inject, input string startTag);
    int cyc;
    int lmrAt;
    @(negedge clk); #2;
    preSeen = 0; refSeen = 0; lmrSeen = 0; firstCmd = -1;
    startPulse = 1'b1;
    @(negedge clk);
    check(busy == 1'b1 && done == 1'b0, startTag, int'(busy), 1);
    #2 startPulse = 1'b0;
    cyc = 0;
    lmrAt = -1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (memCmd == 2'd3) lmrAt = cyc;
      if (inject && cyc == 3) begin #2 startPulse = 1'b1; end
      if (inject && cyc == 4) begin #2 startPulse = 1'b0; end
    end
    check(done == 1'b1, "R7 done reached", int'(done), 1);
    check(cyc - lmrAt == atLeastOne(int'(cfgTmrd)), "R5 tmrd to done", cyc - lmrAt, atLeastOne(int'(cfgTmrd)));
    check(preSeen == 1, inject ? "R8 one precharge" : "R3 one precharge", preSeen, 1);
    check(refSeen == int'(cfgRefreshCnt), "R4 refresh count", refSeen, int'(cfgRefreshCnt));
    check(lmrSeen == 1, "R5 one load-mode", lmrSeen, 1);
    check(firstCmd == 1, "R10 precharge code", firstCmd, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    compareOn = 1;
    repeat (3) @(negedge clk);
    check(memCmd == 2'd0 && memAddr == 14'd0, "R1 reset outputs", int'(memCmd), 0);
    check(!busy && !done, "R1 reset flags", int'(busy) + int'(done), 0);
    #2 rstN = 1'b1;
    tickEn = 1;
    @(negedge clk);
    check(memCmd == 2'd0 && !busy && !done, "R1 after release", int'(memCmd), 0);

    // Typical values, slow tick
    setCfg(16'd5, 4'd8, 14'h220, 4'd2, 4'd6, 4'd2, 3);
    runSeq(0, "R2 start accepted");
    repeat (4) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R7 done holds", int'(done), 1);

    // Zero/short fields: no refresh, one-cycle gaps, zero delay
    setCfg(16'd0, 4'd0, 14'h3fff, 4'd0, 4'd0, 4'd1, 2);
    runSeq(0, "R9 restart from done");

    // One refresh, tick every cycle
    setCfg(16'd1, 4'd1, 14'h1555, 4'd1, 4'd1, 4'd0, 1);
    runSeq(0, "R9 restart from done");

    // Start pulse while busy is ignored
    setCfg(16'd6, 4'd3, 14'h0a5a, 4'd3, 4'd4, 4'd3, 2);
    runSeq(1, "R2 start accepted");

    // Largest timing fields
    setCfg(16'd4, 4'd15, 14'h2aaa, 4'd15, 4'd15, 4'd15, 5);
    runSeq(0, "R9 restart from done");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule